// File: doc/BRIEF.md
# Set-Associative Data Cache Controller

This block is a small data cache between a processor load/store port and a memory port that moves whole lines. The processor presents a byte address, a load or store command and one data byte. It holds that request steady until the cache signals completion. The cache splits the address into offset, set and tag fields. It compares every way of the selected set in parallel and answers a hit in the same cycle. On a miss it fetches the line from memory, first writing back a modified victim if needed, and then completes the access.

Stores allocate on a miss. A parameter selects the store policy. In write-back mode a store changes only the cached copy and marks the line modified. In write-through mode every store also writes its updated line to memory. Replacement fills empty ways from the lowest index upward. Once a set is full, the least recently used way is replaced. Hit and miss event counters are brought out so that a known access trace can be checked.

Top module: `assoc_cache_ctrl`

## Requirements
- R1: The byte offset is the lowest log2(LINE_BYTES) address bits. The set index is the next log2(LINES/WAYS) bits, and the tag is all bits above them. With the defaults (2 ways, 8 lines, 2-byte lines, 8-bit address) this gives a 1-bit offset, a 2-bit set and a 5-bit tag.
- R2: A request that matches a valid line in its set completes in the cycle it is presented, with cpu_ready and cpu_hit both high.
- R3: A load miss keeps cpu_ready low while the line is fetched. The fetch is a memory read at the line address with the offset bits zero, and byte k of the line sits in mem_rdata bits [8k+7:8k]. The load then completes with cpu_hit low and returns the fetched byte.
- R4: A store miss first fetches the line as a load would, then writes its byte into the line. In write-back mode the line becomes modified.
- R5: In write-back mode a store hit changes only the cached byte. No memory write is issued.
- R6: A modified victim is written to memory at its own line address before the refill read starts. The memory request and its address stay stable until mem_ack.
- R7: On a miss, an empty way is used before any valid way is replaced, and the lowest-numbered empty way is taken first.
- R8: With all ways of a set valid, the way whose last use (hit or miss fill) is oldest is replaced. After reset, way 0 counts as the least recent.
- R9: In write-through mode, every store writes its updated line to memory before it completes. No line is ever modified, so no eviction writes back.
- R10: During reset all lines become invalid and clean, both counters read zero, and neither cpu_ready nor mem_req is asserted.
- R11: hit_count rises by one for each request that hits at first lookup, and miss_count rises by one for each request that misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_rdata | output | 8 | Load byte, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_hit | output | 1 | With cpu_ready: access hit at first lookup |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W | Line address, offset bits zero |
| mem_wdata | output | 8*LINE_BYTES | Line written to memory |
| mem_rdata | input | 8*LINE_BYTES | Line read from memory |
| mem_ack | input | 1 | One-cycle completion of the transfer |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
On a miss, victim selection and the recency promotion of that same victim land in one lookup cycle. A hit likewise reorders recency in the cycle where it writes its byte. The bench provokes both by running a tight 64-byte address window with about one store in three, which keeps sets full and conflicting. Every completion's hit flag is judged against a bench model that orders ways by last-use timestamps. Every load byte is judged against a flat golden memory. The number of dirty write-backs the model predicts is compared with the writes seen on the write-back instance's memory port.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;

  typedef enum logic [2:0] {
    ST_LOOK,
    ST_EVICT,
    ST_FILL,
    ST_FINISH,
    ST_WTHRU
  } cache_state_e;

  function automatic int unsigned width_min1(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 1,
  parameter int SET_W  = 2,
  parameter int TAG_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [OFF_W-1:0]  off,
  output logic [SET_W-1:0]  set,
  output logic [TAG_W-1:0]  tag
);

  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return SET_W'(a >> OFF_W);
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return TAG_W'(a >> (OFF_W + SET_W));
  endfunction

  assign off = f_off(addr);
  assign set = f_set(addr);
  assign tag = f_tag(addr);

endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 5,
  parameter int WAY_W = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           req_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       any_hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       free_any,
  output logic [WAY_W-1:0]           free_way
);

  // one comparator per way, all evaluated in parallel
  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_cmp
      assign hit_vec[gw] = way_valid[gw] && (way_tag[gw] == req_tag);
    end
  endgenerate

  // descending scan so the lowest index wins
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])    hit_way  = WAY_W'(w);
      if (!way_valid[w]) free_way = WAY_W'(w);
    end
  end

  assign any_hit  = |hit_vec;
  assign free_any = ~&way_valid;

  // R2: the controller never installs the same tag twice in a set
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] look_set,
  output logic [WAY_W-1:0] lru_way
);

  generate
    if (WAYS > 1) begin : g_rank
      // rank 0 = least recent, WAYS-1 = most recent; a permutation per set
      logic [WAY_W-1:0] rank_q [SETS][WAYS];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
              rank_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
              rank_q[touch_set][w] <= WAY_W'(WAYS - 1);
            else if (rank_q[touch_set][w] > rank_q[touch_set][touch_way])
              rank_q[touch_set][w] <= rank_q[touch_set][w] - 1'b1;
          end
        end
      end

      always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++)
          if (rank_q[look_set][w] == '0) lru_way = WAY_W'(w);
      end

      // R8: a used way becomes the most recent of its set
      p_touch_mru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> rank_q[$past(touch_set)][$past(touch_way)] == WAY_W'(WAYS - 1));
    end else begin : g_direct
      logic unused_in;
      assign unused_in = ^{touch_en, touch_set, touch_way, look_set, clk, rst_n};
      assign lru_way   = '0;
    end
  endgenerate

endmodule

// File: rtl/assoc_cache_ctrl.sv
module assoc_cache_ctrl
  import assoc_cache_pkg::*;
#(
  parameter int WAYS       = 2,
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 2,
  parameter int ADDR_W     = 8,
  parameter int WRITE_BACK = 1,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [7:0]              cpu_wdata,
  output logic [7:0]              cpu_rdata,
  output logic                    cpu_ready,
  output logic                    cpu_hit,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [8*LINE_BYTES-1:0] mem_wdata,
  input  logic [8*LINE_BYTES-1:0] mem_rdata,
  input  logic                    mem_ack,
  output logic [CNT_W-1:0]        hit_count,
  output logic [CNT_W-1:0]        miss_count
);

  localparam int  SETS    = LINES / WAYS;
  localparam int  OFF_W   = $clog2(LINE_BYTES);
  localparam int  SET_W   = $clog2(SETS);
  localparam int  TAG_W   = ADDR_W - OFF_W - SET_W;
  localparam int  BLK_W   = 8 * LINE_BYTES;
  localparam int  WAY_W   = width_min1(WAYS);
  localparam int  LIDX_W  = $clog2(LINES);
  localparam bit  WB_MODE = (WRITE_BACK != 0);

  // ---------------- arithmetic helpers ----------------
  function automatic logic [LIDX_W-1:0] line_of(input logic [SET_W-1:0] s,
                                                input logic [WAY_W-1:0] w);
    return LIDX_W'(int'(s) * WAYS + int'(w));
  endfunction

  function automatic logic [7:0] get_byte(input logic [BLK_W-1:0] blk,
                                          input logic [OFF_W-1:0] o);
    return blk[8*int'(o) +: 8];
  endfunction

  function automatic logic [BLK_W-1:0] put_byte(input logic [BLK_W-1:0] blk,
                                                input logic [OFF_W-1:0] o,
                                                input logic [7:0]       b);
    logic [BLK_W-1:0] r;
    r = blk;
    r[8*int'(o) +: 8] = b;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                  input logic [SET_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  // ---------------- storage ----------------
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [BLK_W-1:0] data_q [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  cache_state_e     state, state_d;
  logic [WAY_W-1:0] way_q;
  logic             was_hit_q;

  // ---------------- address decode ----------------
  logic [OFF_W-1:0] req_off;
  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;

  cache_addr_split #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .TAG_W(TAG_W)
  ) u_split (
    .addr(cpu_addr), .off(req_off), .set(req_set), .tag(req_tag)
  );

  // ---------------- parallel lookup ----------------
  logic [WAYS-1:0]            set_valid;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            hit_vec;
  logic                       any_hit, free_any;
  logic [WAY_W-1:0]           hit_way, free_way, lru_way;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w] = valid_q[line_of(req_set, WAY_W'(w))];
      set_tags[w]  = tag_q[line_of(req_set, WAY_W'(w))];
    end
  end

  cache_tag_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_match (
    .clk(clk), .rst_n(rst_n),
    .way_valid(set_valid), .way_tag(set_tags), .req_tag(req_tag),
    .hit_vec(hit_vec), .any_hit(any_hit), .hit_way(hit_way),
    .free_any(free_any), .free_way(free_way)
  );

  // ---------------- victim choice and events ----------------
  logic [WAY_W-1:0]  v_way;
  logic [LIDX_W-1:0] v_line;
  logic              victim_dirty;
  logic [WAY_W-1:0]  cur_way;
  logic [LIDX_W-1:0] cur_line;

  logic ev_lookup, ev_hit, ev_miss, ev_store_commit;
  logic ev_evict_done, ev_fill_done, ev_wt_done, ev_touch;
  logic hit_done, finish_done;

  assign v_way        = free_any ? free_way : lru_way;
  assign v_line       = line_of(req_set, v_way);
  assign victim_dirty = valid_q[v_line] && dirty_q[v_line];

  assign cur_way  = (state == ST_LOOK) ? (any_hit ? hit_way : v_way) : way_q;
  assign cur_line = line_of(req_set, cur_way);

  assign ev_lookup       = (state == ST_LOOK) && cpu_req;
  assign ev_hit          = ev_lookup && any_hit;
  assign ev_miss         = ev_lookup && !any_hit;
  assign ev_touch        = ev_lookup;
  assign ev_store_commit = cpu_we && (ev_hit || (state == ST_FINISH));
  assign ev_evict_done   = (state == ST_EVICT) && mem_ack;
  assign ev_fill_done    = (state == ST_FILL) && mem_ack;
  assign ev_wt_done      = (state == ST_WTHRU) && mem_ack;

  cache_lru #(
    .WAYS(WAYS), .SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(ev_touch), .touch_set(req_set),
    .touch_way(any_hit ? hit_way : v_way),
    .look_set(req_set), .lru_way(lru_way)
  );

  // ---------------- next state ----------------
  always_comb begin
    state_d = state;
    unique case (state)
      ST_LOOK:
        if (cpu_req) begin
          if (any_hit) state_d = (cpu_we && !WB_MODE) ? ST_WTHRU : ST_LOOK;
          else         state_d = victim_dirty ? ST_EVICT : ST_FILL;
        end
      ST_EVICT:  if (mem_ack) state_d = ST_FILL;
      ST_FILL:   if (mem_ack) state_d = ST_FINISH;
      ST_FINISH: state_d = (cpu_we && !WB_MODE) ? ST_WTHRU : ST_LOOK;
      ST_WTHRU:  if (mem_ack) state_d = ST_LOOK;
      default:   state_d = ST_LOOK;
    endcase
  end

  // ---------------- state and arrays ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_LOOK;
      way_q      <= '0;
      was_hit_q  <= 1'b0;
      valid_q    <= '0;
      dirty_q    <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      for (int l = 0; l < LINES; l++) begin
        tag_q[l]  <= '0;
        data_q[l] <= '0;
      end
    end else begin
      state <= state_d;
      if (ev_hit) begin
        hit_count <= hit_count + 1'b1;
        way_q     <= hit_way;
        was_hit_q <= 1'b1;
      end
      if (ev_miss) begin
        miss_count <= miss_count + 1'b1;
        way_q      <= v_way;
        was_hit_q  <= 1'b0;
      end
      if (ev_evict_done) dirty_q[cur_line] <= 1'b0;
      if (ev_fill_done) begin
        data_q[cur_line]  <= mem_rdata;
        tag_q[cur_line]   <= req_tag;
        valid_q[cur_line] <= 1'b1;
        dirty_q[cur_line] <= 1'b0;
      end
      if (ev_store_commit) begin
        data_q[cur_line] <= put_byte(data_q[cur_line], req_off, cpu_wdata);
        if (WB_MODE) dirty_q[cur_line] <= 1'b1;
      end
    end
  end

  // ---------------- outputs ----------------
  assign hit_done    = ev_hit && (!cpu_we || WB_MODE);
  assign finish_done = (state == ST_FINISH) && (!cpu_we || WB_MODE);

  assign cpu_ready = hit_done || finish_done || ev_wt_done;
  assign cpu_hit   = hit_done || (ev_wt_done && was_hit_q);
  assign cpu_rdata = get_byte(data_q[cur_line], req_off);

  assign mem_req   = (state == ST_EVICT) || (state == ST_FILL) || (state == ST_WTHRU);
  assign mem_we    = (state != ST_FILL);
  assign mem_addr  = (state == ST_EVICT) ? line_addr(tag_q[cur_line], req_set)
                                         : line_addr(req_tag, req_set);
  assign mem_wdata = data_q[cur_line];

  // ---------------- assertions ----------------
  // R6: a refill never overwrites a modified line
  p_no_dirty_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) |-> !(valid_q[cur_line] && dirty_q[cur_line]));

  // R6: memory request held steady until acknowledged
  p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3: a miss never completes in its lookup cycle
  p_miss_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |-> !cpu_ready);

  // R11: each miss advances the miss counter by one
  p_miss_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (miss_count == $past(miss_count) + 1'b1));

  generate
    if (!WB_MODE) begin : g_wt_chk
      // R9: lines stay clean and every store goes to memory
      p_wt_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_q == '0);
      p_wt_store_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_store_commit |=> (state == ST_WTHRU));
    end
  endgenerate

endmodule

// File: tb/sim_assoc_cache_ctrl.sv
`timescale 1ns/1ps
module sim_assoc_cache_ctrl;

  localparam int B    = 2;
  localparam int M    = 8;
  localparam int N    = 2;
  localparam int SETS = M / N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        req   [2];
  logic        we    [2];
  logic [7:0]  addr  [2];
  logic [7:0]  wdata [2];
  logic [7:0]  rdata [2];
  logic        rdy   [2];
  logic        hit   [2];
  logic        mreq  [2];
  logic        mwe   [2];
  logic [7:0]  maddr [2];
  logic [15:0] mwdata[2];
  logic [15:0] mrdata[2];
  logic        ack   [2];
  logic [15:0] hc    [2];
  logic [15:0] mc    [2];

  assoc_cache_ctrl #(.WRITE_BACK(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]),
    .cpu_wdata(wdata[0]), .cpu_rdata(rdata[0]), .cpu_ready(rdy[0]), .cpu_hit(hit[0]),
    .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwdata[0]),
    .mem_rdata(mrdata[0]), .mem_ack(ack[0]), .hit_count(hc[0]), .miss_count(mc[0]));

  assoc_cache_ctrl #(.WRITE_BACK(0)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]),
    .cpu_wdata(wdata[1]), .cpu_rdata(rdata[1]), .cpu_ready(rdy[1]), .cpu_hit(hit[1]),
    .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwdata[1]),
    .mem_rdata(mrdata[1]), .mem_ack(ack[1]), .hit_count(hc[1]), .miss_count(mc[1]));

  // ---------------- memory models, one per instance ----------------
  logic [7:0] memory [2][256];
  logic [1:0] lat [2];
  int         wcnt [2];

  function automatic logic [7:0] init_byte(input int i);
    return 8'(i * 7 + 3);
  endfunction

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        ack[d]  <= 1'b0;
        lat[d]  <= '0;
        wcnt[d] <= 0;
        for (int i = 0; i < 256; i++) memory[d][i] <= init_byte(i);
      end else if (ack[d]) begin
        ack[d] <= 1'b0;
        lat[d] <= '0;
      end else if (mreq[d]) begin
        if (lat[d] == 2'd2) begin
          ack[d] <= 1'b1;
          if (mwe[d]) begin
            memory[d][maddr[d] & 8'hFE] <= mwdata[d][7:0];
            memory[d][maddr[d] | 8'h01] <= mwdata[d][15:8];
            wcnt[d] <= wcnt[d] + 1;
          end
        end else begin
          lat[d] <= lat[d] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int d = 0; d < 2; d++)
      mrdata[d] = {memory[d][maddr[d] | 8'h01], memory[d][maddr[d] & 8'hFE]};
  end

  // ---------------- bookkeeping ----------------
  int checks = 0;
  int errors = 0;
  int pred_wb = 0;
  int pred_hits = 0;
  int nops = 0;
  logic [7:0] golden [256];

  bit     mv  [SETS][N];
  int     mt  [SETS][N];
  bit     md  [SETS][N];
  longint mts [SETS][N];
  longint tick;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // reference model: timestamps of last use, division-based decode
  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int i = 0; i < N; i++) begin
        mv[s][i] = 0; md[s][i] = 0; mt[s][i] = 0; mts[s][i] = i;
      end
    tick = N;
  endtask

  task automatic model_step(input logic [7:0] a, input logic w,
                            output logic h, output logic wb);
    int s, t, way;
    s = (int'(a) / B) % SETS;
    t = int'(a) / (B * SETS);
    way = -1;
    wb = 1'b0;
    for (int i = 0; i < N; i++) if (mv[s][i] && mt[s][i] == t) way = i;
    h = (way >= 0);
    if (!h) begin
      for (int i = N - 1; i >= 0; i--) if (!mv[s][i]) way = i;
      if (way < 0) begin
        way = 0;
        for (int i = 1; i < N; i++) if (mts[s][i] < mts[s][way]) way = i;
        wb = md[s][way];
      end
      mv[s][way] = 1; mt[s][way] = t; md[s][way] = 0;
    end
    if (w) md[s][way] = 1;
    tick++;
    mts[s][way] = tick;
  endtask

  task automatic access(input int d, input logic [7:0] a, input logic w, input logic [7:0] wd,
                        output logic [7:0] rd, output logic h, output int cyc);
    @(negedge clk);
    req[d] = 1'b1; we[d] = w; addr[d] = a; wdata[d] = wd;
    cyc = 0;
    #1;
    while (!rdy[d] && cyc < 60) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    rd = rdata[d];
    h  = hit[d];
    if (cyc >= 60) chk(1'b0, "R3 access timeout", cyc, 60);
    @(negedge clk);
    req[d] = 1'b0;
  endtask

  task automatic run_op(input logic [7:0] a, input logic w, input logic [7:0] wd);
    logic eh, ewb, h;
    logic [7:0] rd;
    int cyc;
    model_step(a, w, eh, ewb);
    if (ewb) pred_wb++;
    if (eh) pred_hits++;
    nops++;
    if (w) golden[a] = wd;
    for (int d = 0; d < 2; d++) begin
      access(d, a, w, wd, rd, h, cyc);
      chk(h == eh, "R8 hit/miss pattern", int'(h), int'(eh));
      if (!w) chk(rd == golden[a], "R3 load data", int'(rd), int'(golden[a]));
      if (eh && (d == 0 || !w)) chk(cyc == 0, "R2 hit completes at once", cyc, 0);
      if (!eh) chk(cyc > 0, "R3 miss stalls", cyc, 1);
      if (w && d == 1) chk(memory[1][a] == wd, "R9 write-through memory", int'(memory[1][a]), int'(wd));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd1357));
    for (int d = 0; d < 2; d++) begin
      req[d] = 1'b0; we[d] = 1'b0; addr[d] = '0; wdata[d] = '0;
    end
    for (int i = 0; i < 256; i++) golden[i] = init_byte(i);
    model_reset();

    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(hc[d] == 0, "R10 hit counter reset", int'(hc[d]), 0);
      chk(mc[d] == 0, "R10 miss counter reset", int'(mc[d]), 0);
      chk(!mreq[d], "R10 no memory request in reset", int'(mreq[d]), 0);
      chk(!rdy[d], "R10 not ready in reset", int'(rdy[d]), 0);
    end
    rst_n = 1'b1;

    // directed trace: set 2 gets 44 and 68, store hit, store miss in set 0, conflict in set 2
    run_op(8'd44, 1'b0, 8'h00);
    run_op(8'd68, 1'b0, 8'h00);
    run_op(8'd45, 1'b1, 8'hA1);   // R1: same line as 44, must hit
    run_op(8'd8,  1'b1, 8'h3C);   // R4: store miss allocates
    run_op(8'd12, 1'b0, 8'h00);   // R7/R8: set full, evicts the clean way holding 68
    for (int d = 0; d < 2; d++) begin
      chk(mc[d] == 4, "R11 miss count of trace", int'(mc[d]), 4);
      chk(hc[d] == 1, "R11 hit count of trace", int'(hc[d]), 1);
    end
    chk(wcnt[0] == 0, "R5 no memory write on write-back stores", wcnt[0], 0);
    chk(wcnt[1] == 2, "R9 each store written through", wcnt[1], 2);
    chk(memory[0][45] == init_byte(45), "R5 memory untouched by store hit",
        int'(memory[0][45]), int'(init_byte(45)));

    run_op(8'd8, 1'b0, 8'h00);    // R4: allocated line returns stored byte
    run_op(8'd76, 1'b0, 8'h00);   // R6: evicts modified line of 44/45
    chk(wcnt[0] == 1, "R6 dirty victim written back", wcnt[0], 1);
    chk(memory[0][45] == 8'hA1, "R6 written-back byte", int'(memory[0][45]), 8'hA1);
    chk(wcnt[1] == 2, "R9 no write-back on eviction", wcnt[1], 2);

    // constrained random phase over a 64-byte window
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      logic       w;
      a = 8'($urandom % 64);
      w = (($urandom % 3) == 0);
      run_op(a, w, 8'($urandom));
    end

    // read back the window through the write-back cache
    for (int a = 0; a < 64; a++) run_op(8'(a), 1'b0, 8'h00);

    chk(wcnt[0] == pred_wb, "R6 write-back count", wcnt[0], pred_wb);
    for (int d = 0; d < 2; d++) begin
      chk(int'(hc[d]) == pred_hits, "R11 final hit count", int'(hc[d]), pred_hits);
      chk(int'(hc[d]) + int'(mc[d]) == nops, "R11 hits plus misses", int'(hc[d]) + int'(mc[d]), nops);
    end

    finish_run();
  end

endmodule